// File: doc/BRIEF.md
# General-Purpose Pin Register Bank

This block is a bank of up to 32 general-purpose pins controlled through four writable 32-bit registers and one read-only view. Software sets the static level driven on each pin, chooses whether each pin is driven or left as an input, picks pins whose driven level should flash on a shared slow square wave, and chooses per pin whether the value read back from the pad is inverted. Each pad input is brought into the clock domain by two flip-flops before the polarity inversion is applied.

The register port is a plain strobe bus. A write strobe with an address and a 32-bit word updates a register at the next rising edge. A read strobe returns the selected word on `rdata` one cycle later, and `rdata` then holds that word until the next read. There is no back-pressure: every strobe is accepted in the cycle it is presented, and no data stream enters or leaves the block. The pin-side outputs `pin_out` and `pin_oe` come straight from registers through a single gate level. Blinking is driven by a free-running prescaler whose period is a parameter.

Top module: `gpio_bank`

## Requirements
- R1: After reset, the output-level register and the blink-select register read 0, the direction register reads 1 in every populated bit, and the polarity register reads 0. While reset is asserted, and afterwards until they are rewritten, `pin_oe` and `pin_out` are 0.
- R2: Byte offsets 0x00 (output level), 0x04 (direction), 0x08 (blink select) and 0x0C (input polarity) are readable and writable. A read strobe sampled at one rising edge places the word on `rdata` after that edge, and `rdata` holds that word while no read strobe is present.
- R3: `pin_oe[i]` is the inverse of direction bit i. A direction bit of 1 makes pin i an input with its driver off.
- R4: When blink-select bit i is 0, `pin_out[i]` equals output-level bit i from the edge on which that bit is written.
- R5: When blink-select bit i is 1, `pin_out[i]` equals output-level bit i XOR a shared blink phase. The blink phase is 0 after reset and toggles once every BLINK_DIV clock cycles.
- R6: A read of offset 0x10 returns the pad input XOR the polarity register, bit by bit. A pad change is not visible to a read strobe sampled on the first or second rising edge after the change, and is visible to one sampled on the third.
- R7: Bits at positions NUM_PINS and above read as 0 in every register and view. Writing them has no effect.
- R8: Writes to offset 0x10 and to any unmapped offset change no register. Reads of unmapped offsets (for example 0x02 or 0x14) return 0.
- R9: When a read and a write to the same offset share a cycle, `rdata` returns the value held before that write, and the new value is returned by the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for all registers |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, one word per cycle |
| rd_en | input | 1 | Read strobe, one word per cycle |
| addr | input | ADDR_W | Byte offset of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered one cycle after `rd_en` |
| pin_in | input | NUM_PINS | Asynchronous pad inputs |
| pin_out | output | NUM_PINS | Level driven on each pin |
| pin_oe | output | NUM_PINS | Driver enable for each pin (1 drives the pin) |

## Verification
Two functions can fall in the same cycle: a register read and a write to the same offset, and a blink-phase toggle together with an output-level write. The bench raises both strobes at once on the output-level register. It checks that the returned word is the value before the write and that the following read returns the new value. For the second case it writes the output level right after a measured phase edge and checks that the pin shows the new level XOR the phase that was just observed. It also checks that the next phase edge comes exactly BLINK_DIV cycles after the previous one.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

  localparam int unsigned WORD_W = 32;

  localparam int unsigned OFS_LEVEL = 'h00;
  localparam int unsigned OFS_DIR   = 'h04;
  localparam int unsigned OFS_BLINK = 'h08;
  localparam int unsigned OFS_POL   = 'h0C;
  localparam int unsigned OFS_VIEW  = 'h10;

  localparam int unsigned NUM_RW = 4;

  typedef enum logic [2:0] {
    SEL_LEVEL = 3'd0,
    SEL_DIR   = 3'd1,
    SEL_BLINK = 3'd2,
    SEL_POL   = 3'd3,
    SEL_VIEW  = 3'd4,
    SEL_NONE  = 3'd7
  } reg_sel_e;

  function automatic logic [WORD_W-1:0] pin_mask(input int unsigned n);
    logic [WORD_W-1:0] m;
    m = '0;
    for (int unsigned b = 0; b < WORD_W; b++) begin
      if (b < n) m[b] = 1'b1;
    end
    return m;
  endfunction

endpackage

// File: rtl/gpio_in_sync.sv
module gpio_in_sync #(
  parameter int unsigned NUM_PINS = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pad_in,
  output logic [NUM_PINS-1:0] pad_sync
);

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic meta_q;
    logic stable_q;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        meta_q   <= 1'b0;
        stable_q <= 1'b0;
      end else begin
        meta_q   <= pad_in[i];
        stable_q <= meta_q;
      end
    end

    assign pad_sync[i] = stable_q;
  end

endmodule

// File: rtl/gpio_blink_gen.sv
module gpio_blink_gen #(
  parameter int unsigned BLINK_DIV = 1 << 20
) (
  input  logic clk,
  input  logic rst_n,
  output logic phase
);

  localparam int unsigned CNT_W = (BLINK_DIV > 1) ? $clog2(BLINK_DIV) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(BLINK_DIV - 1);

  logic [CNT_W-1:0] cnt_q;
  logic             phase_q;
  logic             wrap;

  assign wrap = (cnt_q == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      phase_q <= 1'b0;
    end else if (wrap) begin
      cnt_q   <= '0;
      phase_q <= ~phase_q;
    end else begin
      cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign phase = phase_q;

endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [WORD_W-1:0]   wdata,
  input  logic [NUM_PINS-1:0] pad_sync,
  output logic [WORD_W-1:0]   rdata,
  output logic [NUM_PINS-1:0] level_bits,
  output logic [NUM_PINS-1:0] dir_bits,
  output logic [NUM_PINS-1:0] blink_bits,
  output logic [NUM_PINS-1:0] pol_bits
);

  localparam logic [WORD_W-1:0] MASK = pin_mask(NUM_PINS);

  reg_sel_e          sel;
  logic [WORD_W-1:0] rw_q [NUM_RW];
  logic [WORD_W-1:0] view_word;
  logic [WORD_W-1:0] rd_word;
  logic [WORD_W-1:0] rdata_q;

  always_comb begin
    if      (addr == ADDR_W'(OFS_LEVEL)) sel = SEL_LEVEL;
    else if (addr == ADDR_W'(OFS_DIR))   sel = SEL_DIR;
    else if (addr == ADDR_W'(OFS_BLINK)) sel = SEL_BLINK;
    else if (addr == ADDR_W'(OFS_POL))   sel = SEL_POL;
    else if (addr == ADDR_W'(OFS_VIEW))  sel = SEL_VIEW;
    else                                 sel = SEL_NONE;
  end

  for (genvar k = 0; k < NUM_RW; k++) begin : g_rw
    localparam logic [WORD_W-1:0] RST = (k == int'(SEL_DIR)) ? MASK : '0;
    logic hit;
    assign hit = wr_en && (sel == reg_sel_e'(k));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        rw_q[k] <= RST;
      end else if (hit) begin
        rw_q[k] <= wdata & MASK;
      end
    end
  end

  assign level_bits = rw_q[SEL_LEVEL][NUM_PINS-1:0];
  assign dir_bits   = rw_q[SEL_DIR][NUM_PINS-1:0];
  assign blink_bits = rw_q[SEL_BLINK][NUM_PINS-1:0];
  assign pol_bits   = rw_q[SEL_POL][NUM_PINS-1:0];

  assign view_word = (WORD_W'(pad_sync) ^ rw_q[SEL_POL]) & MASK;

  always_comb begin
    case (sel)
      SEL_LEVEL: rd_word = rw_q[SEL_LEVEL];
      SEL_DIR:   rd_word = rw_q[SEL_DIR];
      SEL_BLINK: rd_word = rw_q[SEL_BLINK];
      SEL_POL:   rd_word = rw_q[SEL_POL];
      SEL_VIEW:  rd_word = view_word;
      default:   rd_word = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q <= '0;
    end else if (rd_en) begin
      rdata_q <= rd_word;
    end
  end

  assign rdata = rdata_q;

endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS  = 32,
  parameter int unsigned ADDR_W    = 8,
  parameter int unsigned BLINK_DIV = 1 << 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic                rd_en,
  input  logic [ADDR_W-1:0]   addr,
  input  logic [31:0]         wdata,
  output logic [31:0]         rdata,
  input  logic [NUM_PINS-1:0] pin_in,
  output logic [NUM_PINS-1:0] pin_out,
  output logic [NUM_PINS-1:0] pin_oe
);

  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] out_q;
  logic [NUM_PINS-1:0] dir_q;
  logic [NUM_PINS-1:0] blink_q;
  logic [NUM_PINS-1:0] pol_q;
  logic                phase;

  gpio_in_sync #(.NUM_PINS(NUM_PINS)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_in   (pin_in),
    .pad_sync (pad_sync)
  );

  gpio_blink_gen #(.BLINK_DIV(BLINK_DIV)) u_blink (
    .clk   (clk),
    .rst_n (rst_n),
    .phase (phase)
  );

  gpio_bank_regs #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .wr_en      (wr_en),
    .rd_en      (rd_en),
    .addr       (addr),
    .wdata      (wdata),
    .pad_sync   (pad_sync),
    .rdata      (rdata),
    .level_bits (out_q),
    .dir_bits   (dir_q),
    .blink_bits (blink_q),
    .pol_bits   (pol_q)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_drive
    assign pin_oe[i]  = ~dir_q[i];
    assign pin_out[i] = out_q[i] ^ (blink_q[i] & phase);
  end

endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk
  import gpio_bank_pkg::*;
#(
  parameter int unsigned NUM_PINS = 32,
  parameter int unsigned ADDR_W   = 8
) (
  input logic                clk,
  input logic                rst_n,
  input logic                wr_en,
  input logic                rd_en,
  input logic [ADDR_W-1:0]   addr,
  input logic [NUM_PINS-1:0] wr_bits,
  input logic [31:0]         rdata,
  input logic [NUM_PINS-1:0] pin_out,
  input logic [NUM_PINS-1:0] pin_oe,
  input logic [NUM_PINS-1:0] out_q,
  input logic [NUM_PINS-1:0] dir_q,
  input logic [NUM_PINS-1:0] blink_q
);

  AST_RESET_PINS_QUIET: assert property (@(posedge clk)
    !rst_n |=> (pin_oe == '0 && pin_out == '0)); // R1

  AST_RDATA_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rdata)); // R2

  AST_OE_FROM_DIR_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_DIR)) |=> (pin_oe == ~$past(wr_bits))); // R3

  AST_STATIC_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_LEVEL) && blink_q == '0) |=> (pin_out == $past(wr_bits))); // R4

  AST_VIEW_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ADDR_W'(OFS_VIEW)) |=> ($stable(out_q) && $stable(dir_q) && $stable(blink_q))); // R8

  AST_COLLISION_OLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && rd_en && addr == ADDR_W'(OFS_LEVEL)) |=> (rdata == 32'($past(out_q)))); // R9

endmodule

bind gpio_bank gpio_bank_chk #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .wr_en   (wr_en),
  .rd_en   (rd_en),
  .addr    (addr),
  .wr_bits (wdata[NUM_PINS-1:0]),
  .rdata   (rdata),
  .pin_out (pin_out),
  .pin_oe  (pin_oe),
  .out_q   (out_q),
  .dir_q   (dir_q),
  .blink_q (blink_q)
);

// File: tb/tb_gpio_bank.sv
module tb_gpio_bank;

  localparam int unsigned NP  = 20;
  localparam int unsigned AW  = 8;
  localparam int unsigned DIV = 16;
  localparam logic [31:0] M   = 32'h000F_FFFF;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [31:0]   wdata = '0;
  logic [31:0]   rdata;
  logic [NP-1:0] pin_in = '0;
  logic [NP-1:0] pin_out;
  logic [NP-1:0] pin_oe;

  int n_chk = 0;
  int n_bad = 0;

  always #4 clk = ~clk;

  gpio_bank #(.NUM_PINS(NP), .ADDR_W(AW), .BLINK_DIV(DIV)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .pin_in(pin_in), .pin_out(pin_out), .pin_oe(pin_oe)
  );

  typedef struct packed {
    logic        is_wr;
    logic [7:0]  a;
    logic [31:0] d;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 8'h00, 32'h0000_0000, 4'd1},  // R1 level reset
    '{1'b0, 8'h04, 32'h000F_FFFF, 4'd1},  // R1 direction reset
    '{1'b0, 8'h08, 32'h0000_0000, 4'd1},  // R1 blink reset
    '{1'b0, 8'h0C, 32'h0000_0000, 4'd1},  // R1 polarity reset
    '{1'b1, 8'h00, 32'hA5A5_A5A5, 4'd7},  // R7 upper bits dropped
    '{1'b0, 8'h00, 32'h0005_A5A5, 4'd7},
    '{1'b1, 8'h04, 32'h0000_F0F0, 4'd2},  // R2
    '{1'b0, 8'h04, 32'h0000_F0F0, 4'd2},
    '{1'b1, 8'h08, 32'h0001_2345, 4'd2},
    '{1'b0, 8'h08, 32'h0001_2345, 4'd2},
    '{1'b1, 8'h0C, 32'hFFFF_FFFF, 4'd7},
    '{1'b0, 8'h0C, 32'h000F_FFFF, 4'd7},
    '{1'b1, 8'h10, 32'hFFFF_FFFF, 4'd8},  // R8 view write ignored
    '{1'b0, 8'h00, 32'h0005_A5A5, 4'd8},
    '{1'b1, 8'h14, 32'hDEAD_BEEF, 4'd8},  // R8 unmapped
    '{1'b0, 8'h14, 32'h0000_0000, 4'd8},
    '{1'b0, 8'h02, 32'h0000_0000, 4'd8}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the next falling edge.
  task automatic bus_wr(input logic [7:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [7:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    finish_run();
  end

  initial begin
    logic [31:0] r;
    logic        p;
    int          gap;
    repeat (3) @(negedge clk);
    // R1 pins quiet in reset
    check(pin_oe == '0 && pin_out == '0, "R1", {pin_oe[11:0], pin_out}, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NV; v++) begin
      if (VECS[v].is_wr) begin
        bus_wr(VECS[v].a, VECS[v].d);
      end else begin
        bus_rd(VECS[v].a, r);
        check(r == VECS[v].d, $sformatf("R%0d vec%0d", VECS[v].req, v), r, VECS[v].d);
      end
    end

    // R3: direction 0xF0F0 gives enables on the complement
    check(32'(pin_oe) == (~32'h0000_F0F0 & M), "R3", 32'(pin_oe), ~32'h0000_F0F0 & M);
    // R2: rdata holds without a read strobe
    repeat (2) @(negedge clk);
    check(rdata == 32'h0, "R2 hold", rdata, 32'h0);

    // R4: blink off, pins show the level register
    bus_wr(8'h08, 32'h0);
    bus_wr(8'h0C, 32'h0);
    check(32'(pin_out) == 32'h0005_A5A5, "R4", 32'(pin_out), 32'h0005_A5A5);

    // R6: input view and its two-stage latency
    pin_in = 20'h3C3C3;
    repeat (4) @(negedge clk);
    bus_rd(8'h10, r);
    check(r == 32'h0003_C3C3, "R6 view", r, 32'h0003_C3C3);
    bus_wr(8'h0C, 32'h0000_000F);
    bus_rd(8'h10, r);
    check(r == 32'h0003_C3CC, "R6 polarity", r, 32'h0003_C3CC);
    pin_in = 20'h00000;
    bus_rd(8'h10, r);
    check(r == 32'h0003_C3CC, "R6 edge1 old", r, 32'h0003_C3CC);
    bus_rd(8'h10, r);
    check(r == 32'h0003_C3CC, "R6 edge2 old", r, 32'h0003_C3CC);
    bus_rd(8'h10, r);
    check(r == 32'h0000_000F, "R6 edge3 new", r, 32'h0000_000F);

    // R9: read and write of the same register in one cycle
    rd_en = 1'b1; wr_en = 1'b1; addr = 8'h00; wdata = 32'h0001_1111;
    @(negedge clk);
    rd_en = 1'b0; wr_en = 1'b0;
    check(rdata == 32'h0005_A5A5, "R9 old value", rdata, 32'h0005_A5A5);
    bus_rd(8'h00, r);
    check(r == 32'h0001_1111, "R9 new value", r, 32'h0001_1111);

    // R5: blink on pin 0 with level 0
    bus_wr(8'h00, 32'h0);
    bus_wr(8'h08, 32'h1);
    p = pin_out[0];
    gap = 0;
    while (pin_out[0] == p && gap < 4 * DIV) begin
      @(negedge clk);
      gap++;
    end
    p = pin_out[0];
    gap = 0;
    while (pin_out[0] == p && gap < 4 * DIV) begin
      @(negedge clk);
      gap++;
    end
    check(gap == DIV, "R5 period", gap, DIV);
    check(pin_out[1] == 1'b0, "R4 non-blink pin", 32'(pin_out[1]), 32'd0);
    p = pin_out[0];
    bus_wr(8'h00, 32'h1);
    check(pin_out[0] == ~p, "R5 level xor phase", 32'(pin_out[0]), 32'(~p));
    bus_wr(8'h08, 32'h0);
    check(pin_out[0] == 1'b1, "R4 blink off", 32'(pin_out[0]), 32'd1);

    finish_run();
  end

endmodule